// File: doc/BRIEF.md
# Dual-Read Dual-Write Register File with Null Identifier

This block stores a small bank of general-purpose data words for a processor datapath. It has two read ports and two write ports, and all four can be used in the same cycle. Each port carries a 4-bit register identifier. A read port returns the selected word combinationally. A write port stores its data word on the rising clock edge.

The identifier value 0xF means "no register". When a write port carries this identifier, nothing is stored on that edge. When a read port carries it, the port returns zero. Only identifiers 0x0 to 0xE name real storage, so the file holds fifteen words. If both write ports name the same register in one cycle, the memory-side port (port M) takes priority. A synchronous active-high reset clears every word.

Top module: `regbank_2r2w`

## Requirements
- R1: After a cycle with `rst` high, every register 0x0 to 0xE reads back zero.
- R2: `rd_a_data` shows the stored word selected by `rd_a_id` combinationally, with no clock edge needed.
- R3: `rd_b_data` shows the stored word selected by `rd_b_id` combinationally, independent of read port A.
- R4: On a rising edge where `wr_e_id` is not 0xF, `wr_e_data` is stored into register `wr_e_id`.
- R5: On a rising edge where `wr_m_id` is not 0xF, `wr_m_data` is stored into register `wr_m_id`.
- R6: A write port whose identifier is 0xF changes no register.
- R7: A read with identifier 0xF returns zero on that read port.
- R8: When both write ports name the same non-0xF register on one edge, that register takes `wr_m_data`.
- R9: A read of a register that is being written in the same cycle returns the old value until the edge, and the new value after it.
- R10: Two different registers written on the same edge by the two write ports both take their own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_id | input | 4 | Read port A identifier (0xF = none) |
| rd_a_data | output | 64 | Read port A data |
| rd_b_id | input | 4 | Read port B identifier (0xF = none) |
| rd_b_data | output | 64 | Read port B data |
| wr_e_id | input | 4 | Write port E identifier (0xF = none) |
| wr_e_data | input | 64 | Write port E data |
| wr_m_id | input | 4 | Write port M identifier (0xF = none), has priority |
| wr_m_data | input | 64 | Write port M data |

## Verification
The bench drives both write ports at the same register with different data. A design with the priority reversed would keep the E-port value. It writes with identifier 0xF while watching all fifteen registers, so an extra sixteenth entry or a decode that leaks into register 0xE would corrupt visible state. It also reads 0xF on both ports after filling the file with nonzero data, which exposes a file that returns stale storage instead of zero. Reads sampled just before and just after a same-register write show whether the design bypasses the new data early or delays it by a cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int unsigned RB_WORD_W = 64;
   localparam int unsigned RB_ID_W   = 4;
   localparam int unsigned RB_NULL   = (1 << RB_ID_W) - 1;

   typedef struct packed {
      logic [RB_ID_W-1:0]   id;
      logic [RB_WORD_W-1:0] data;
   } rb_wr_t;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
   parameter int unsigned ID_W    = 4,
   parameter int unsigned ENTRIES = 15
) (
   input  logic [ID_W-1:0]    id,
   output logic [ENTRIES-1:0] hit
);
   initial begin
      if (ENTRIES >= (1 << ID_W))
         $error("regbank_decode: ENTRIES must leave the null identifier free");
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_hit
      assign hit[g] = (id == ID_W'(g));
   end
endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux #(
   parameter int unsigned WORD_W  = 64,
   parameter int unsigned ID_W    = 4,
   parameter int unsigned ENTRIES = 15
) (
   input  logic [ENTRIES-1:0][WORD_W-1:0] store,
   input  logic [ID_W-1:0]                id,
   output logic [WORD_W-1:0]              data
);
   logic [ENTRIES-1:0] sel;

   regbank_decode #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_dec (
      .id  (id),
      .hit (sel)
   );

   always_comb begin
      data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         data = data | (store[i] & {WORD_W{sel[i]}});
      end
   end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
   parameter int unsigned WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_e,
   input  logic [WORD_W-1:0] d_e,
   input  logic              we_m,
   input  logic [WORD_W-1:0] d_m,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (we_m) q <= d_m;
      else if (we_e) q <= d_e;
   end
endmodule

// File: rtl/regbank_2r2w.sv
module regbank_2r2w
   import regbank_pkg::*;
#(
   parameter int unsigned WORD_W  = RB_WORD_W,
   parameter int unsigned ID_W    = RB_ID_W,
   parameter int unsigned ENTRIES = (1 << ID_W) - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   rd_a_id,
   output logic [WORD_W-1:0] rd_a_data,
   input  logic [ID_W-1:0]   rd_b_id,
   output logic [WORD_W-1:0] rd_b_data,
   input  logic [ID_W-1:0]   wr_e_id,
   input  logic [WORD_W-1:0] wr_e_data,
   input  logic [ID_W-1:0]   wr_m_id,
   input  logic [WORD_W-1:0] wr_m_data
);
   initial begin
      if (WORD_W < 1) $error("regbank_2r2w: WORD_W must be positive");
      if (ENTRIES < 1 || ENTRIES >= (1 << ID_W))
         $error("regbank_2r2w: ENTRIES out of range for ID_W");
   end

   logic [ENTRIES-1:0][WORD_W-1:0] store;
   logic [ENTRIES-1:0]             hit_e;
   logic [ENTRIES-1:0]             hit_m;

   regbank_decode #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_dec_e (
      .id (wr_e_id), .hit (hit_e)
   );
   regbank_decode #(.ID_W(ID_W), .ENTRIES(ENTRIES)) u_dec_m (
      .id (wr_m_id), .hit (hit_m)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
      regbank_cell #(.WORD_W(WORD_W)) u_cell (
         .clk  (clk),
         .rst  (rst),
         .we_e (hit_e[g]),
         .d_e  (wr_e_data),
         .we_m (hit_m[g]),
         .d_m  (wr_m_data),
         .q    (store[g])
      );
   end

   regbank_readmux #(.WORD_W(WORD_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) u_rd_a (
      .store (store), .id (rd_a_id), .data (rd_a_data)
   );
   regbank_readmux #(.WORD_W(WORD_W), .ID_W(ID_W), .ENTRIES(ENTRIES)) u_rd_b (
      .store (store), .id (rd_b_id), .data (rd_b_data)
   );
endmodule

// File: rtl/regbank_2r2w_chk.sv
module regbank_2r2w_chk #(
   parameter int unsigned WORD_W = 64,
   parameter int unsigned ID_W   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [ID_W-1:0]   rd_a_id,
   input logic [WORD_W-1:0] rd_a_data,
   input logic [ID_W-1:0]   rd_b_id,
   input logic [WORD_W-1:0] rd_b_data,
   input logic [ID_W-1:0]   wr_e_id,
   input logic [WORD_W-1:0] wr_e_data,
   input logic [ID_W-1:0]   wr_m_id,
   input logic [WORD_W-1:0] wr_m_data
);
   localparam logic [ID_W-1:0] NULL_ID = '1;

   logic was_rst;
   always_ff @(posedge clk) was_rst <= rst;

   AST_NULL_READ_A: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id == NULL_ID) |-> (rd_a_data == '0)) else $error("null read A"); // R7
   AST_NULL_READ_B: assert property (@(posedge clk) disable iff (rst)
      (rd_b_id == NULL_ID) |-> (rd_b_data == '0)) else $error("null read B"); // R7
   AST_CLEARED_A: assert property (@(posedge clk)
      (was_rst && rst) |-> (rd_a_data == '0)) else $error("not cleared"); // R1
   AST_M_WINS: assert property (@(posedge clk) disable iff (rst)
      (wr_m_id != NULL_ID && rd_a_id == wr_m_id && !rst)
      |=> (rst || $changed(rd_a_id) || rd_a_data == $past(wr_m_data)))
      else $error("M write lost"); // R8
   AST_E_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_e_id != NULL_ID && wr_m_id != wr_e_id && rd_b_id == wr_e_id)
      |=> (rst || $changed(rd_b_id) || rd_b_data == $past(wr_e_data)))
      else $error("E write lost"); // R4
   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
      (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data))
      else $error("ports disagree"); // R3
endmodule

bind regbank_2r2w regbank_2r2w_chk #(.WORD_W(WORD_W), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst(rst),
   .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
   .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
   .wr_e_id(wr_e_id), .wr_e_data(wr_e_data),
   .wr_m_id(wr_m_id), .wr_m_data(wr_m_data)
);

// File: tb/regbank_2r2w_test.sv
module regbank_2r2w_test;
   localparam int CLK_PERIOD = 10;
   localparam int NREG = 15;

   logic        clk = 0;
   logic        rst;
   logic [3:0]  rd_a_id, rd_b_id, wr_e_id, wr_m_id;
   logic [63:0] rd_a_data, rd_b_data, wr_e_data, wr_m_data;

   int checks = 0;
   int fails  = 0;
   logic [63:0] model [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   regbank_2r2w uut (
      .clk(clk), .rst(rst),
      .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
      .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
      .wr_e_id(wr_e_id), .wr_e_data(wr_e_data),
      .wr_m_id(wr_m_id), .wr_m_data(wr_m_data)
   );

   function automatic logic [63:0] ref_read(input logic [3:0] id);
      if (id == 4'hF) return 64'd0;
      return model[id];
   endfunction

   // reference model: update on each edge
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) model[i] <= 64'd0;
      end else begin
         if (wr_e_id != 4'hF) model[wr_e_id] <= wr_e_data;
         if (wr_m_id != 4'hF) model[wr_m_id] <= wr_m_data;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of both read ports against the model
   always @(negedge clk) begin
      if (!rst) begin
         chk("R2 port A", rd_a_data, ref_read(rd_a_id));
         chk("R3 port B", rd_b_data, ref_read(rd_b_id));
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle_wr();
      wr_e_id = 4'hF; wr_m_id = 4'hF; wr_e_data = '0; wr_m_data = '0;
   endtask

   task automatic read_at(input logic [3:0] a, input logic [3:0] b);
      rd_a_id = a; rd_b_id = b; #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst = 1; idle_wr(); rd_a_id = 0; rd_b_id = 1;
      wr_e_id = 4'd3; wr_e_data = 64'hDEAD;
      step(); step();
      rst = 0; idle_wr();
      // R1: everything cleared
      for (int i = 0; i < NREG; i++) begin
         read_at(4'(i), 4'(i));
         chk("R1 clear", rd_a_data, 64'd0);
      end
      // R4 / R5 / R10: fill all registers using both ports
      for (int i = 0; i < NREG; i += 2) begin
         wr_e_id = 4'(i); wr_e_data = 64'h1111_0000_0000_0000 + 64'(i);
         wr_m_id = (i + 1 < NREG) ? 4'(i + 1) : 4'hF;
         wr_m_data = 64'h2222_0000_0000_0000 + 64'(i + 1);
         step();
      end
      idle_wr();
      read_at(4'd4, 4'd5);
      chk("R4 E write", rd_a_data, 64'h1111_0000_0000_0004);
      chk("R5 M write", rd_b_data, 64'h2222_0000_0000_0005);
      read_at(4'd14, 4'd13);
      chk("R10 dual write E", rd_a_data, 64'h1111_0000_0000_000E);
      chk("R10 dual write M", rd_b_data, 64'h2222_0000_0000_000D);
      // R7: null read returns zero on both ports
      read_at(4'hF, 4'hF);
      chk("R7 null A", rd_a_data, 64'd0);
      chk("R7 null B", rd_b_data, 64'd0);
      // R6: null writes change nothing
      wr_e_id = 4'hF; wr_e_data = 64'hBAD0; wr_m_id = 4'hF; wr_m_data = 64'hBAD1;
      step(); idle_wr();
      for (int i = 0; i < NREG; i++) begin
         read_at(4'(i), 4'hF);
         chk("R6 null write", rd_a_data,
             (i % 2 == 0) ? 64'h1111_0000_0000_0000 + 64'(i)
                          : 64'h2222_0000_0000_0000 + 64'(i));
      end
      // R8: same register on both ports, M wins
      wr_e_id = 4'd7; wr_e_data = 64'hE0E0; wr_m_id = 4'd7; wr_m_data = 64'hA5A5;
      step(); idle_wr();
      read_at(4'd7, 4'd7);
      chk("R8 M priority", rd_a_data, 64'hA5A5);
      // R9: old value before edge, new after
      read_at(4'd2, 4'd2);
      wr_e_id = 4'd2; wr_e_data = 64'h0123_4567_89AB_CDEF; #1;
      chk("R9 old value", rd_a_data, 64'h1111_0000_0000_0002);
      step(); idle_wr();
      chk("R9 new value", rd_b_data, 64'h0123_4567_89AB_CDEF);
      // R2: combinational read changes without a clock edge
      @(negedge clk);
      read_at(4'd5, 4'd0);
      chk("R2 comb A", rd_a_data, 64'h2222_0000_0000_0005);
      read_at(4'd6, 4'd1);
      chk("R2 comb A", rd_a_data, 64'h1111_0000_0000_0006);
      chk("R3 comb B", rd_b_data, 64'h2222_0000_0000_0001);
      // pattern sweep
      for (int k = 0; k < 40; k++) begin
         wr_e_id = 4'((k * 7) % 16); wr_e_data = {32'(k), 32'hCAFE0000 + 32'(k)};
         wr_m_id = 4'((k * 5 + 3) % 16); wr_m_data = {32'hF00D0000 + 32'(k), 32'(k)};
         rd_a_id = 4'((k * 3) % 16); rd_b_id = 4'((k * 11) % 16);
         step();
      end
      idle_wr();
      // R1 again: reset after traffic
      rst = 1; step(); rst = 0;
      for (int i = 0; i < NREG; i++) begin
         read_at(4'(i), 4'(NREG - 1 - i));
         chk("R1 reclear", rd_a_data | rd_b_data, 64'd0);
      end
      step();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule